// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. Software programs it through a small 32-bit register port: a timer entry that holds the interrupt vector, a mask bit and a mode bit; an initial count; and a divide configuration. The base clock passes through a power-of-two prescaler, and each prescaled tick lowers the current count by one. The current count can be read back at any time.

When the count expires, the block sends a one-cycle request that carries the programmed 8-bit vector to the interrupt priority logic, unless the entry is masked. In one-shot mode the count stops at zero and expires once. In periodic mode it reloads and expires every initial-count-plus-one ticks. Writing the initial count restarts both the count and the prescaler.

Top module: `lapic_cdtimer`

## Requirements
- R1: After reset, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0). The initial count, the current count and the divide configuration read 0, and no request is raised.
- R2: The divide configuration keeps only write-data bits 3, 1 and 0. Every other bit reads back as 0.
- R3: The divide code is {bit 3, bit 1, bit 0}. The prescale shift is (code + 1) modulo 8, so one tick occurs every 2^shift clocks: code 7 divides by 1, code 0 by 2, code 1 by 4 and code 4 by 32.
- R4: In the timer entry, bit 16 is the mask, bit 17 selects periodic mode (1) or one-shot mode (0), and bits 7:0 are the vector. The full written word reads back unchanged.
- R5: A write to the initial count sets the current count to the written value and restarts the prescaler, so the first tick comes 2^shift clocks after the write edge.
- R6: In one-shot mode, the current count equals initial minus elapsed ticks and holds at 0 once the elapsed ticks reach the initial count.
- R7: In one-shot mode with a nonzero initial count N, exactly one request occurs, on the (N+1)-th tick after the load. A one-shot load of 0 never raises a request.
- R8: In periodic mode, the current count equals initial minus (elapsed modulo (initial + 1)), and a request occurs every initial + 1 ticks.
- R9: While the entry is masked, no request is raised, but the count keeps running.
- R10: A rewrite of the timer entry in one-shot mode, made after the count has reached 0 but before the expiry tick, cancels that pending expiry.
- R11: A request is the registered output irq_valid, high for one clock, with irq_vector equal to the entry's vector. It appears one clock after the expiry tick edge.
- R12: Register indices are 0 for the timer entry, 1 for the initial count, 2 for the current count and 3 for the divide configuration. A write to index 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_idx | input | 2 | Register index for reads |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions assume that the write port is never used while reset is held. They also assume that an entry write and an initial-count write never fall on the same edge. The bench issues one register write at a time, outside reset. The assertions also assume that the priority logic samples irq_valid on every clock. Every expiry the bench expects lands on a clock edge that it computes from the load edge, the divide shift and the count.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int IDX_W    = 2;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  typedef enum logic [IDX_W-1:0] {
    IDX_ENTRY = 2'd0,
    IDX_INIT  = 2'd1,
    IDX_CUR   = 2'd2,
    IDX_DIV   = 2'd3
  } reg_idx_e;

  // scrambled code {b3,b1,b0}; shift = code+1 wrapping in 3 bits
  function automatic logic [2:0] div_shift(input logic [3:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/lct_regs.sv
module lct_regs
  import lct_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] entry_q,
  output logic [DATA_W-1:0] init_q,
  output logic [3:0]        div_q,
  output logic              load,
  output logic              entry_wr
);
  localparam logic [DATA_W-1:0] ENTRY_RST = DATA_W'(1) << MASK_BIT;

  assign load     = wr_en && (wr_idx == IDX_INIT);
  assign entry_wr = wr_en && (wr_idx == IDX_ENTRY);

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= ENTRY_RST;
      init_q  <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_ENTRY: entry_q <= wr_data;
        IDX_INIT:  init_q  <= wr_data;
        IDX_DIV:   div_q   <= {wr_data[3], 1'b0, wr_data[1:0]};
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] sel;

  assign sel  = ~({PRE_W{1'b1}} << shift);
  assign tick = ((pre_q & sel) == sel);

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] init_val,
  input  logic              tick,
  input  logic              periodic,
  input  logic              masked,
  input  logic [VEC_W-1:0]  vector,
  input  logic              entry_wr,
  input  logic              new_periodic,
  output logic [DATA_W-1:0] cur_q,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic armed_q;
  logic zero;
  logic fire;

  assign zero = (cur_q == '0);
  assign fire = !load && tick && zero && (periodic || armed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      armed_q    <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= fire && !masked;
      irq_vector <= vector;
      if (load) begin
        cur_q   <= load_val;
        armed_q <= (load_val != '0);
      end else begin
        if (tick) begin
          if (!zero)         cur_q <= cur_q - 1'b1;
          else if (periodic) cur_q <= init_val;
        end
        if ((fire && !periodic) || (entry_wr && !new_periodic && zero))
          armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lapic_cdtimer.sv
module lapic_cdtimer
  import lct_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 8,
  parameter int SHIFT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_idx,
  output logic [31:0]       rd_data,
  output logic              irq_valid,
  output logic [7:0]        irq_vector
);
  logic [DATA_W-1:0] entry_q;
  logic [DATA_W-1:0] init_q;
  logic [3:0]        div_q;
  logic [DATA_W-1:0] cur_q;
  logic              load;
  logic              entry_wr;
  logic              tick;

  lct_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .entry_q(entry_q), .init_q(init_q), .div_q(div_q),
    .load(load), .entry_wr(entry_wr)
  );

  lct_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst(rst), .restart(load),
    .shift(div_shift(div_q)), .tick(tick)
  );

  lct_counter #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .init_val(init_q),
    .tick(tick), .periodic(entry_q[PER_BIT]), .masked(entry_q[MASK_BIT]),
    .vector(entry_q[VEC_W-1:0]), .entry_wr(entry_wr),
    .new_periodic(wr_data[PER_BIT]),
    .cur_q(cur_q), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always_comb begin
    case (rd_idx)
      IDX_ENTRY: rd_data = entry_q;
      IDX_INIT:  rd_data = init_q;
      IDX_CUR:   rd_data = cur_q;
      default:   rd_data = {{(DATA_W-4){1'b0}}, div_q};
    endcase
  end
endmodule

// File: rtl/lct_chk.sv
module lct_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [1:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [31:0] entry_q,
  input logic [31:0] cur_q,
  input logic        irq_valid,
  input logic [7:0]  irq_vector
);
  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> !$past(entry_q[16]));

  // R7
  expire_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ($past(cur_q) == 32'd0));

  // R11
  vector_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vector == $past(entry_q[7:0])));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 2'd1) |=> (cur_q == $past(wr_data)));

  // R6
  oneshot_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_idx == 2'd1) && !entry_q[17] |=> (cur_q <= $past(cur_q)));

  // R1
  reset_entry_chk: assert property (@(posedge clk)
    $past(rst) && !rst |-> (entry_q == 32'h0001_0000 && !irq_valid));
endmodule

bind lapic_cdtimer lct_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .entry_q(entry_q), .cur_q(cur_q), .irq_valid(irq_valid),
  .irq_vector(irq_vector)
);

// File: tb/lapic_cdtimer_tb.sv
`timescale 1ns/1ps
module lapic_cdtimer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int exp_cyc[$];
  int exp_vec[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lapic_cdtimer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int c, input int v);
    exp_cyc.push_back(c);
    exp_vec.push_back(v);
  endtask

  // monitor: pops expected requests as the design produces them
  always @(negedge clk) begin
    if (!rst && irq_valid) begin
      if (exp_cyc.size() == 0) begin
        chk("R7/R9 unexpected request", 32'(cyc), 32'hFFFF_FFFF);
      end else begin
        int c, v;
        c = exp_cyc.pop_front();
        v = exp_vec.pop_front();
        chk("R11 request cycle", 32'(cyc), 32'(c));
        chk("R11 request vector", {24'd0, irq_vector}, 32'(v));
      end
    end
  end

  task automatic wr(input int idx, input logic [31:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[1:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    e = cyc;
  endtask

  task automatic wait_to(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    rd_idx = idx[1:0];
    #1;
    v = rd_data;
  endtask

  task automatic drained(input string req);
    chk(req, 32'(exp_cyc.size()), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int e, e2, dummy;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 entry", v, 32'h0001_0000);
    rd(1, v); chk("R1 initial", v, 32'd0);
    rd(2, v); chk("R1 current", v, 32'd0);
    rd(3, v); chk("R1 divide", v, 32'd0);

    // R2 divide mask
    wr(3, 32'hFFFF_FFFF, dummy);
    rd(3, v); chk("R2 divide readback", v, 32'h0000_000B);

    // R3 code 7 -> divide by 1; R6 R7 one-shot
    wr(0, 32'h0000_0041, dummy);
    rd(0, v); chk("R4 entry readback", v, 32'h0000_0041);
    wr(1, 32'd5, e);
    push(e + 6, 8'h41);
    wait_to(e + 2); rd(2, v); chk("R6 count div1", v, 32'd3);
    wait_to(e + 5); rd(2, v); chk("R6 count at zero", v, 32'd0);
    wait_to(e + 14); rd(2, v); chk("R6 holds zero", v, 32'd0);
    drained("R7 single one-shot request");

    // R12 write to current index ignored
    wr(2, 32'h55, dummy);
    rd(2, v); chk("R12 current not writable", v, 32'd0);

    // R3 code 0 -> divide by 2
    wr(3, 32'h0, dummy);
    wr(0, 32'h0000_0023, dummy);
    wr(1, 32'd3, e);
    push(e + 8, 8'h23);
    wait_to(e + 3); rd(2, v); chk("R3 count div2", v, 32'd2);
    wait_to(e + 7); rd(2, v); chk("R3 count div2 zero", v, 32'd0);
    wait_to(e + 20); drained("R3 div2 expiry");

    // R3 code 4 via bit 3 -> divide by 32
    wr(3, 32'h8, dummy);
    rd(3, v); chk("R2 bit3 kept", v, 32'h8);
    wr(1, 32'd1, e);
    push(e + 64, 8'h23);
    wait_to(e + 40); rd(2, v); chk("R3 count div32", v, 32'd0);
    wait_to(e + 75); drained("R3 div32 expiry");

    // R8 periodic, code 1 -> divide by 4
    wr(3, 32'h1, dummy);
    wr(0, 32'h0002_0077, dummy);
    rd(0, v); chk("R4 periodic entry readback", v, 32'h0002_0077);
    wr(1, 32'd2, e);
    push(e + 12, 8'h77); push(e + 24, 8'h77); push(e + 36, 8'h77);
    wait_to(e + 5);  rd(2, v); chk("R8 periodic count", v, 32'd1);
    wait_to(e + 13); rd(2, v); chk("R8 periodic reload", v, 32'd2);
    wait_to(e + 40);
    wr(0, 32'h0003_0077, dummy);
    wait_to(e + 60); drained("R8 three periodic requests, R9 masked after");
    rd(2, v); chk("R9 count runs while masked", v, 32'd2);

    // R9 masked one-shot
    wr(3, 32'hB, dummy);
    wr(0, 32'h0001_0041, dummy);
    wr(1, 32'd3, e);
    wait_to(e + 2); rd(2, v); chk("R9 masked count", v, 32'd1);
    wait_to(e + 10); drained("R9 masked no request");

    // R5 reload restarts
    wr(0, 32'h0000_0055, dummy);
    wr(1, 32'd10, e);
    wait_to(e + 3);
    wr(1, 32'd2, e2);
    push(e2 + 3, 8'h55);
    wait_to(e2 + 1); rd(2, v); chk("R5 restart count", v, 32'd1);
    wait_to(e2 + 15); drained("R5 single request after reload");

    // R7 one-shot load of zero
    wr(1, 32'd0, e);
    wait_to(e + 10); drained("R7 zero load no request");
    rd(2, v); chk("R7 zero load count", v, 32'd0);

    // R10 entry rewrite after zero cancels expiry (divide by 4, init 1)
    wr(3, 32'h1, dummy);
    wr(0, 32'h0000_0066, dummy);
    wr(1, 32'd1, e);
    wait_to(e + 5); rd(2, v); chk("R10 count zero", v, 32'd0);
    wr(0, 32'h0000_0066, dummy);
    wait_to(e + 20); drained("R10 cancelled expiry");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule